// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block turns a three-wire stereo serial audio stream into parallel samples. The stream has a bit clock, a data line and a word clock that marks which channel is on the line. Each sample is 16 bits, two's complement, sent MSB first. All three pins are asynchronous to the block's system clock. Each one passes through a multi-stage synchroniser. The block then looks for rising bit-clock edges in the system clock domain, and it samples the data line and the word clock at those edges.

Two framings can be chosen at runtime. In the right-justified framing, a channel's word ends on the last bit-clock rise before the word clock changes level, and a slot may be longer than 16 bits. In the I2S-style framing, the word starts one bit clock after the word-clock change. Once both channels of a frame are assembled, the block presents the left and right words together with a one-cycle strobe. A separate configuration input swaps which word-clock level means left.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted and after it is released, `left_o` and `right_o` read zero and `pair_valid_o` stays low until a full pair has been captured.
- R2: With `cfg_i2s`=0 (right-justified), a bit-clock rise that sees a new word-clock level ends the previous slot. The data bits sampled on the 16 rises just before that rise become the previous slot's sample, earliest bit as MSB. Any extra leading bits in a slot longer than 16 are dropped.
- R3: With `cfg_i2s`=1, the rise that sees the word-clock change is position 0, and positions 1 to 16 carry the sample, MSB first. Position 16 may be the next slot's position 0, as happens with 32 bit clocks per frame. Bits after position 16 in a longer slot are ignored.
- R4: With `cfg_swap_lr`=0, a high word clock marks the left channel. With `cfg_swap_lr`=1, a low word clock marks the left channel. This mapping applies in both framings.
- R5: `pair_valid_o` pulses for exactly one system cycle when a right sample is stored. In that cycle, `right_o` holds the new right sample and `left_o` holds the left sample of the same frame. `right_o` changes in no other cycle.
- R6: After reset or any change of `cfg_i2s` or `cfg_swap_lr`, nothing is captured until the word clock enters the left level. Strobes then occur exactly once per complete frame.
- R7: When the configuration changes mid-stream without a reset, frames that follow the next entry into the left level are decoded in the new framing and polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run several times faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Serial bit clock, data sampled on its rising edge |
| wclk | input | 1 | Word clock selecting the channel |
| sdata | input | 1 | Serial data, MSB first |
| cfg_i2s | input | 1 | 0: right-justified framing, 1: I2S-style framing |
| cfg_swap_lr | input | 1 | 0: word clock high is left, 1: word clock low is left |
| left_o | output | SAMPLE_W | Last captured left sample |
| right_o | output | SAMPLE_W | Last captured right sample |
| pair_valid_o | output | 1 | One-cycle strobe: left and right form a fresh pair |

## Verification
The bench drives right-justified slots of exactly 16 bits and slots padded to 20 and 24 bits with random leading bits. A design that shifted only a fixed count after the edge would return the padding instead of the sample. For I2S framing, it uses 16-bit slots, where the LSB lands on the next slot's first clock. A design that captured at the word edge would then be off by one bit and lose the LSB. It also uses 24-bit slots with random trailing bits, which must be ignored. Swapped polarity, extreme codes (0x8000, 0x7FFF, 0xFFFF, 0x0000) and mid-stream configuration changes without a reset are also covered. A receiver that did not disarm on a configuration change would emit a stray strobe built from the preamble, and the bench counts strobes exactly.

// File: rtl/sar_pkg.sv
package sar_pkg;
   typedef enum logic {
      FMT_RJ  = 1'b0,
      FMT_I2S = 1'b1
   } fmt_e;

   // bit positions inside the synchronised pin bundle
   localparam int PIN_BCLK  = 0;
   localparam int PIN_WCLK  = 1;
   localparam int PIN_SDATA = 2;
   localparam int PIN_COUNT = 3;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pins_i,
   output logic [WIDTH-1:0] pins_o,
   output logic             rise0_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sar_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("sar_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;
   logic                         bit0_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain     <= '0;
         bit0_last <= 1'b0;
      end else begin
         chain     <= {chain[STAGES-2:0], pins_i};
         bit0_last <= chain[STAGES-1][0];
      end
   end

   assign pins_o  = chain[STAGES-1];
   assign rise0_o = chain[STAGES-1][0] & ~bit0_last;

   AST_RISE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
      rise0_o |=> !rise0_o); // R2
endmodule

// File: rtl/sar_frame.sv
module sar_frame
   import sar_pkg::*;
#(
   parameter int SAMPLE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bit_rise_i,
   input  logic                ws_i,
   input  logic                sd_i,
   input  fmt_e                fmt_i,
   input  logic                swap_i,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                pair_valid_o
);
   localparam int CNT_W = $clog2(SAMPLE_W + 1);
   localparam logic [CNT_W-1:0] POS_LAST = CNT_W'(SAMPLE_W - 1);
   localparam logic [CNT_W-1:0] POS_SAT  = CNT_W'(SAMPLE_W);

   if (SAMPLE_W < 2) begin : g_bad_width
      $error("sar_frame: SAMPLE_W must be at least 2");
   end

   logic [SAMPLE_W-1:0] shreg;
   logic [SAMPLE_W-1:0] shifted;
   logic [CNT_W-1:0]    pos;
   logic                ws_last, slot_left, armed, valid_q;
   logic [1:0]          cfg_last;
   logic                cfg_chg, ws_edge, lvl_left;
   logic                cap, cap_left;
   logic [SAMPLE_W-1:0] cap_word;

   always_comb begin
      cfg_chg  = {fmt_i, swap_i} != cfg_last;
      ws_edge  = ws_i != ws_last;
      lvl_left = ws_i ^ swap_i;
      shifted  = {shreg[SAMPLE_W-2:0], sd_i};
      if (fmt_i == FMT_I2S) begin
         cap      = bit_rise_i && (pos == POS_LAST) && armed && !cfg_chg;
         cap_left = slot_left;
         cap_word = shifted;
      end else begin
         cap      = bit_rise_i && ws_edge && armed && !cfg_chg;
         cap_left = !lvl_left;
         cap_word = shreg;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg     <= '0;
         pos       <= '0;
         ws_last   <= 1'b0;
         slot_left <= 1'b0;
         armed     <= 1'b0;
         cfg_last  <= 2'b00;
         valid_q   <= 1'b0;
      end else begin
         cfg_last <= {fmt_i, swap_i};
         valid_q  <= cap && !cap_left;
         if (bit_rise_i) begin
            shreg   <= shifted;
            ws_last <= ws_i;
            if (ws_edge) begin
               pos       <= '0;
               slot_left <= lvl_left;
            end else if (pos != POS_SAT) begin
               pos <= pos + 1'b1;
            end
         end
         if (cfg_chg)
            armed <= 1'b0;
         else if (bit_rise_i && ws_edge && lvl_left)
            armed <= 1'b1;
      end
   end

   // one holding register per channel: index 0 left, index 1 right
   for (genvar ch = 0; ch < 2; ch++) begin : g_chan
      logic [SAMPLE_W-1:0] hold;
      always_ff @(posedge clk) begin
         if (!rst_n)
            hold <= '0;
         else if (cap && (cap_left == (ch == 0)))
            hold <= cap_word;
      end
   end

   assign left_o       = g_chan[0].hold;
   assign right_o      = g_chan[1].hold;
   assign pair_valid_o = valid_q;

   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid_o |=> !pair_valid_o); // R5
   AST_RIGHT_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(right_o) |-> pair_valid_o); // R5
   AST_DISARM_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({fmt_i, swap_i}) |=> !armed); // R6
   AST_STROBE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid_o |-> armed); // R6
   AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pos <= POS_SAT); // R3
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
   import sar_pkg::*;
#(
   parameter int SAMPLE_W    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bclk,
   input  logic                wclk,
   input  logic                sdata,
   input  logic                cfg_i2s,
   input  logic                cfg_swap_lr,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                pair_valid_o
);
   if (SAMPLE_W < 2) begin : g_bad_sample
      $error("serial_audio_rx: SAMPLE_W must be at least 2");
   end

   logic [PIN_COUNT-1:0] pins_raw, pins_s;
   logic                 bit_rise;
   fmt_e                 fmt;

   always_comb begin
      pins_raw            = '0;
      pins_raw[PIN_BCLK]  = bclk;
      pins_raw[PIN_WCLK]  = wclk;
      pins_raw[PIN_SDATA] = sdata;
   end

   assign fmt = cfg_i2s ? FMT_I2S : FMT_RJ;

   sar_sync #(
      .WIDTH  (PIN_COUNT),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pins_i  (pins_raw),
      .pins_o  (pins_s),
      .rise0_o (bit_rise)
   );

   sar_frame #(
      .SAMPLE_W (SAMPLE_W)
   ) u_frame (
      .clk          (clk),
      .rst_n        (rst_n),
      .bit_rise_i   (bit_rise),
      .ws_i         (pins_s[PIN_WCLK]),
      .sd_i         (pins_s[PIN_SDATA]),
      .fmt_i        (fmt),
      .swap_i       (cfg_swap_lr),
      .left_o       (left_o),
      .right_o      (right_o),
      .pair_valid_o (pair_valid_o)
   );
endmodule

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;
   localparam int W    = 16;
   localparam int HALF = 3;
   localparam int PRE  = 5;
   localparam int TR   = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bclk = 1'b0, wclk = 1'b0, sdata = 1'b0;
   logic cfg_i2s = 1'b0, cfg_swap_lr = 1'b0;
   logic [W-1:0] left_o, right_o;
   logic pair_valid_o;

   always #2 clk = ~clk;

   serial_audio_rx u_dut (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .wclk(wclk), .sdata(sdata),
      .cfg_i2s(cfg_i2s), .cfg_swap_lr(cfg_swap_lr),
      .left_o(left_o), .right_o(right_o), .pair_valid_o(pair_valid_o));

   int checks = 0, fails = 0;
   int mon_checks = 0, mon_fails = 0;
   int n_got = 0;
   logic [W-1:0] got_l [0:255];
   logic [W-1:0] got_r [0:255];
   logic [W-1:0] exp_l [0:15];
   logic [W-1:0] exp_r [0:15];
   logic s_ws [0:2047];
   logic s_d  [0:2047];
   logic prev_valid = 1'b0;
   logic done = 1'b0;

   // monitor: records each strobe and checks its width (R5)
   always @(negedge clk) begin
      if (rst_n) begin
         if (pair_valid_o) begin
            got_l[n_got[7:0]] <= left_o;
            got_r[n_got[7:0]] <= right_o;
            n_got <= n_got + 1;
            if (prev_valid) begin
               mon_checks <= mon_checks + 1;
               mon_fails  <= mon_fails + 1;
               $display("FAIL R5 strobe width: actual 2+ cycles expected 1");
            end
         end
      end
      prev_valid <= rst_n & pair_valid_o;
   end

   task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      bclk = 1'b0;
      repeat (4) @(negedge clk);
      check(left_o == '0, "R1 left at reset", 32'(left_o), 0);
      check(right_o == '0, "R1 right at reset", 32'(right_o), 0);
      check(pair_valid_o == 1'b0, "R1 strobe at reset", 32'(pair_valid_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic run_case(input logic fmt, input logic swap, input int slot, input int nfr,
                           input logic with_reset, input string tag);
      int total;
      int base;
      logic llev;
      llev = ~swap;
      cfg_i2s = fmt;
      cfg_swap_lr = swap;
      if (with_reset) do_reset();
      repeat (4) @(negedge clk);
      total = PRE + 2 * nfr * slot + TR;
      for (int i = 0; i < total; i++) begin
         s_d[i] = 1'($urandom);
         if (i < PRE) s_ws[i] = swap;
         else if (i >= PRE + 2 * nfr * slot) s_ws[i] = llev;
         else s_ws[i] = (((i - PRE) / slot) % 2 == 0) ? llev : swap;
      end
      for (int f = 0; f < nfr; f++) begin
         for (int c = 0; c < 2; c++) begin
            int st;
            logic [W-1:0] wd;
            st = PRE + (2 * f + c) * slot;
            wd = (c == 0) ? exp_l[f] : exp_r[f];
            for (int j = 0; j < W; j++) begin
               int p;
               p = fmt ? (st + 1 + j) : (st + slot - W + j);
               s_d[p] = wd[W-1-j];
            end
         end
      end
      base = n_got;
      for (int i = 0; i < total; i++) begin
         bclk = 1'b0;
         wclk = s_ws[i];
         sdata = s_d[i];
         repeat (HALF) @(negedge clk);
         bclk = 1'b1;
         repeat (HALF) @(negedge clk);
      end
      bclk = 1'b0;
      repeat (20) @(negedge clk);
      check(n_got - base == nfr, {tag, " R6 strobe count"}, 32'(n_got - base), 32'(nfr));
      for (int f = 0; f < nfr && f < n_got - base; f++) begin
         check(got_l[base + f] == exp_l[f], {tag, " left"}, 32'(got_l[base + f]), 32'(exp_l[f]));
         check(got_r[base + f] == exp_r[f], {tag, " right"}, 32'(got_r[base + f]), 32'(exp_r[f]));
      end
   endtask

   task automatic fill_random(input int nfr);
      for (int f = 0; f < nfr; f++) begin
         exp_l[f] = W'($urandom);
         exp_r[f] = W'($urandom);
      end
   endtask

   task automatic fill_corners();
      exp_l[0] = 16'h8000; exp_r[0] = 16'h7FFF;
      exp_l[1] = 16'hFFFF; exp_r[1] = 16'h0000;
      exp_l[2] = 16'h0001; exp_r[2] = 16'hA5C3;
      exp_l[3] = 16'h1234; exp_r[3] = 16'hFFFE;
   endtask

   initial begin
      void'($urandom(32'd4242));
      fill_corners();
      run_case(1'b0, 1'b0, 16, 4, 1'b1, "R2 rj slot16");
      fill_random(4);
      run_case(1'b0, 1'b0, 24, 4, 1'b1, "R2 rj slot24 padded");
      fill_random(3);
      run_case(1'b0, 1'b1, 20, 3, 1'b1, "R4 R2 rj swapped slot20");
      fill_corners();
      run_case(1'b1, 1'b0, 16, 4, 1'b1, "R3 i2s 32clk frame");
      fill_random(3);
      run_case(1'b1, 1'b1, 24, 3, 1'b1, "R4 R3 i2s swapped slot24");
      fill_random(3);
      run_case(1'b0, 1'b0, 16, 3, 1'b0, "R7 switch to rj");
      fill_random(3);
      run_case(1'b1, 1'b1, 32, 3, 1'b0, "R7 switch to i2s swapped");
      for (int k = 0; k < 4; k++) begin
         logic rf, rs;
         int rslot;
         rf = 1'($urandom);
         rs = 1'($urandom);
         rslot = 16 + int'($urandom % 17);
         fill_random(2);
         run_case(rf, rs, rslot, 2, 1'b1, "R2 R3 R4 random");
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures",
               checks + mon_checks, fails + mon_fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures",
                  checks + mon_checks + 1, fails + mon_fails + 1);
         $finish;
      end
   end
endmodule